// File: doc/BRIEF.md
# Two-Wire Control Slave with Paired-Byte Register Loading

This block is the serial control port of a frequency synthesiser. It watches a two-wire bus (clock and data, open drain). The bus signals are oversampled by a much faster system clock, so both standard and fast bus rates work. The block recognises START and STOP, compares the incoming 7-bit address with its own, and acknowledges when they match. The five high address bits are fixed by a parameter. The low bits come from a select input, so several devices can share one bus.

In a write transaction, data bytes arrive in pairs. The top bit of the first byte of each pair picks the kind of pair:
- A clear flag marks a divide pair. The two bytes together form a 15-bit divide word.
- A set flag marks a control pair. It loads the reference-ratio select, the pump setting and a set of mode bits.

Pairs can follow one another without addressing the device again, until STOP. In a read transaction, the block shifts out a status byte. It keeps doing so while the master acknowledges, and stops as soon as the master does not.

Top module: `i2c_synth_slave`

## Requirements
- R1: While reset is held and directly after it is released, every register output is zero and `sda_low` is 0, so the data line is released.
- R2: An address byte whose 7 high bits (sent MSB first) equal `{ADDR_HI, addr_sel}` gets an acknowledge: `sda_low` is 1 through the ninth clock. Bit 0 of that byte selects the direction: 0 means write, 1 means read.
- R3: An address that does not match gets no acknowledge. Bytes that follow it do not change any output, and the block stays silent until the next START.
- R4: In write mode every data byte is acknowledged. `sda_low` changes only after a falling SCL edge and is held for the whole high phase of SCL.
- R5: A first-of-pair byte with bit 7 = 0 stages its bits 6:0 as divide bits 14:8. The next byte gives bits 7:0. `div_word` changes only when that second byte is complete, never after the first one alone.
- R6: A first-of-pair byte with bit 7 = 1 loads `pump_set` from bits 6:5 and `ratio_sel` from bits 4:0. The next byte loads the mode bits as follows:
  - `test_mode` from bits 7:5
  - `path_sel` from bit 4
  - `osc_sel` from bit 3
  - `refbuf_en` from bit 2
  - `port_out` from bit 1
  - bit 0 is ignored.
- R7: After a complete pair, the next byte is again decoded as first-of-pair by its bit 7, with no new address, until STOP.
- R8: In read mode the block sends `status_i`, MSB first. The value is captured at the end of the address acknowledge and again at the end of each master acknowledge.
- R9: If the master leaves SDA high in a read acknowledge slot, the block releases the line and sends nothing more. A further byte clocked out reads 0xFF.
- R10: A START in the middle of a pair, repeated or not, throws away the staged byte and restarts the pairing with the first byte after the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen at the pin |
| sda_i | input | 1 | Bus data as seen at the pin |
| addr_sel | input | SEL_W | Low address bits from the select input |
| status_i | input | 8 | Status byte returned in read mode |
| sda_low | output | 1 | 1 pulls the data line low |
| div_word | output | 15 | Committed divide word |
| ratio_sel | output | 5 | Reference ratio select |
| pump_set | output | 2 | Pump current setting |
| test_mode | output | 3 | Test mode select |
| path_sel | output | 1 | Baseband path select |
| osc_sel | output | 1 | Oscillator select |
| refbuf_en | output | 1 | Reference buffer enable |
| port_out | output | 1 | Output port bit |

## Verification
The bench builds the block with its defaults: `SEL_W` = 2 and `ADDR_HI` = 5'b11000. With a two-bit select, the bench can drive a matching select value and a non-matching one. It can also switch the select input between transactions and check that the accepted address follows it. Eight-bit status values with mixed bit patterns, read over several acknowledged bytes, show the MSB-first order and the recapture of the status after each master acknowledge. A behavioural model of the pairing rule is compared on every clock. It covers back-to-back pairs, a half-written divide pair cut off by a repeated START, and bytes sent after a non-matching address.

// File: rtl/i2c_synth_slave.sv
module i2c_synth_slave #(
  parameter int SEL_W = 2,
  parameter logic [6-SEL_W:0] ADDR_HI = 5'b11000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] addr_sel,
  input  logic [7:0]       status_i,
  output logic             sda_low,
  output logic [14:0]      div_word,
  output logic [4:0]       ratio_sel,
  output logic [1:0]       pump_set,
  output logic [2:0]       test_mode,
  output logic             path_sel,
  output logic             osc_sel,
  output logic             refbuf_en,
  output logic             port_out
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2,
                         S_WDAT = 3'd3, S_WACK = 3'd4, S_RDAT = 3'd5, S_RACK = 3'd6;

  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;
  logic [2:0] state_q;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, mack, second_q, kind_q;
  logic [6:0] hi_q;

  wire scl_s   = scl_m[1];
  wire sda_s   = sda_m[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;

  assign sda_low = (state_q == S_AACK) || (state_q == S_WACK) ||
                   (state_q == S_RDAT && !sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt       <= '0;
      sh        <= '1;
      rw        <= 1'b0;
      mack      <= 1'b0;
      second_q  <= 1'b0;
      kind_q    <= 1'b0;
      hi_q      <= '0;
      div_word  <= '0;
      ratio_sel <= '0;
      pump_set  <= '0;
      test_mode <= '0;
      path_sel  <= 1'b0;
      osc_sel   <= 1'b0;
      refbuf_en <= 1'b0;
      port_out  <= 1'b0;
    end else if (start_c) begin
      state_q  <= S_ADDR;
      cnt      <= '0;
      second_q <= 1'b0;
    end else if (stop_c) begin
      state_q  <= S_IDLE;
      second_q <= 1'b0;
    end else begin
      case (state_q)
        S_ADDR, S_WDAT: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (state_q == S_ADDR) begin
              if (sh[7:1] == {ADDR_HI, addr_sel}) begin
                state_q <= S_AACK;
                rw      <= sh[0];
              end else begin
                state_q <= S_IDLE;
              end
            end else begin
              state_q <= S_WACK;
              if (!second_q) begin
                second_q <= 1'b1;
                kind_q   <= sh[7];
                if (!sh[7]) hi_q <= sh[6:0];
                else begin
                  pump_set  <= sh[6:5];
                  ratio_sel <= sh[4:0];
                end
              end else begin
                second_q <= 1'b0;
                if (!kind_q) div_word <= {hi_q, sh};
                else begin
                  test_mode <= sh[7:5];
                  path_sel  <= sh[4];
                  osc_sel   <= sh[3];
                  refbuf_en <= sh[2];
                  port_out  <= sh[1];
                end
              end
            end
          end
        end
        S_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            state_q <= S_RDAT;
            sh      <= status_i;
          end else begin
            state_q <= S_WDAT;
          end
        end
        S_WACK: if (scl_fall) begin
          state_q <= S_WDAT;
          cnt     <= '0;
        end
        S_RDAT: if (scl_fall) begin
          if (cnt == 4'd7) state_q <= S_RACK;
          else begin
            sh  <= {sh[6:0], 1'b1};
            cnt <= cnt + 4'd1;
          end
        end
        S_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          if (scl_fall) begin
            if (mack) begin
              state_q <= S_RDAT;
              sh      <= status_i;
              cnt     <= '0;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_synth_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        scl_q,
  input logic        sda_low,
  input logic [2:0]  state_q,
  input logic        second_q,
  input logic [14:0] div_word,
  input logic [4:0]  ratio_sel,
  input logic [2:0]  test_mode
);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'd0) |-> !sda_low);

  p_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |=> $stable(sda_low));

  p_drive_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> $past(scl_q && !scl_s));

  p_div_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_word != $past(div_word)) |-> ($past(state_q) == 3'd3 && $past(second_q)));

  p_ctrl_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_sel != $past(ratio_sel)) |-> ($past(state_q) == 3'd3 && !$past(second_q)));

  p_ctrl_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode != $past(test_mode)) |-> ($past(state_q) == 3'd3 && $past(second_q)));
endmodule

bind i2c_synth_slave i2c_synth_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q), .sda_low(sda_low),
  .state_q(state_q), .second_q(second_q), .div_word(div_word),
  .ratio_sel(ratio_sel), .test_mode(test_mode)
);

// File: tb/i2c_synth_slave_tb.sv
module i2c_synth_slave_tb_top;
  localparam int Q = 10;
  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic [1:0] addr_sel = 2'b01;
  logic [7:0] status_i = 8'h00;
  logic sda_low;
  logic [14:0] div_word;
  logic [4:0] ratio_sel;
  logic [1:0] pump_set;
  logic [2:0] test_mode;
  logic path_sel, osc_sel, refbuf_en, port_out;
  wire sda_bus = m_sda & ~sda_low;

  always #2.5 clk = ~clk;

  i2c_synth_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .addr_sel(addr_sel),
    .status_i(status_i), .sda_low(sda_low), .div_word(div_word), .ratio_sel(ratio_sel),
    .pump_set(pump_set), .test_mode(test_mode), .path_sel(path_sel), .osc_sel(osc_sel),
    .refbuf_en(refbuf_en), .port_out(port_out)
  );

  int n_chk = 0, n_err = 0;
  logic cmp_en = 0;

  // behavioural model of the register side
  logic [14:0] m_div = 0;
  logic [4:0]  m_ratio = 0;
  logic [1:0]  m_pump = 0;
  logic [2:0]  m_test = 0;
  logic [3:0]  m_bits = 0;
  logic        m_on = 0, m_second = 0, m_kind = 0;
  logic [6:0]  m_hi = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    n_chk++;
    if ({div_word, ratio_sel, pump_set, test_mode, path_sel, osc_sel, refbuf_en, port_out} !==
        {m_div, m_ratio, m_pump, m_test, m_bits}) begin
      n_err++;
      $display("FAIL R5/R6/R7 per-cycle regs actual=%0h expected=%0h",
        {div_word, ratio_sel, pump_set, test_mode, path_sel, osc_sel, refbuf_en, port_out},
        {m_div, m_ratio, m_pump, m_test, m_bits});
    end
  end

  task automatic m_byte(input logic [7:0] b);
    if (!m_on) return;
    if (!m_second) begin
      m_second = 1; m_kind = b[7];
      if (!b[7]) m_hi = b[6:0];
      else begin m_pump = b[6:5]; m_ratio = b[4:0]; end
    end else begin
      m_second = 0;
      if (!m_kind) m_div = {m_hi, b};
      else begin m_test = b[7:5]; m_bits = b[4:1]; end
    end
  endtask

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic start_c();
    m_sda = 1; q(); m_scl = 1; q(); m_sda = 0; q(); m_scl = 0; q();
    m_second = 0;
  endtask

  task automatic stop_c();
    m_sda = 0; q(); m_scl = 1; q(); m_sda = 1; q();
    m_on = 0; m_second = 0;
  endtask

  task automatic wbit(input logic b);
    m_sda = b; q(); m_scl = 1; q(); q(); m_scl = 0; q();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1; q(); m_scl = 1; q(); b = sda_bus; q(); m_scl = 0; q();
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag, input logic data);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) cmp_en = 0;
      wbit(b[i]);
    end
    if (data) m_byte(b);
    cmp_en = 1;
    rbit(a);
    chk(tag, !a, exp_ack);
  endtask

  task automatic addr(input logic [6:0] a, input logic rd, input logic match, input string tag);
    m_on = match && !rd;
    send({a, rd}, match, tag, 0);
  endtask

  task automatic rbyte(output logic [7:0] b, input logic mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin rbit(x); b[i] = x; end
    wbit(!mack);
  endtask

  logic [7:0] rd;

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset regs", {div_word, ratio_sel, pump_set, test_mode, path_sel, osc_sel, refbuf_en, port_out}, 0);
    chk("R1 reset sda", sda_low, 0);
    rst_n = 1;
    q();
    chk("R1 after release sda", sda_low, 0);
    cmp_en = 1;

    // divide pair, half-pair check
    start_c();
    addr(7'b1100001, 0, 1, "R2 address ack");
    send(8'h12, 1, "R4 byte2 ack", 1);
    chk("R5 divide not committed after first byte", div_word, 0);
    send(8'h34, 1, "R4 byte3 ack", 1);
    chk("R5 divide word", div_word, 15'h1234);
    stop_c();

    // control pair then further pairs without readdressing
    start_c();
    addr(7'b1100001, 0, 1, "R2 address ack 2");
    send(8'hC5, 1, "R6 byte4 ack", 1);
    chk("R6 ratio", ratio_sel, 5'h05);
    chk("R6 pump", pump_set, 2'b10);
    send(8'hB7, 1, "R6 byte5 ack", 1);
    chk("R6 mode bits", {test_mode, path_sel, osc_sel, refbuf_en, port_out}, 7'b1011011);
    send(8'h7F, 1, "R7 next pair ack", 1);
    send(8'hFF, 1, "R7 next pair ack2", 1);
    chk("R7 divide max", div_word, 15'h7FFF);
    send(8'h80, 1, "R7 third pair", 1);
    send(8'h00, 1, "R7 third pair 2", 1);
    chk("R7 control cleared", {ratio_sel, pump_set, test_mode, path_sel, osc_sel, refbuf_en, port_out}, 0);
    stop_c();

    // non-matching address
    start_c();
    addr(7'b1100010, 0, 0, "R3 mismatch no ack");
    send(8'h05, 0, "R3 data ignored", 1);
    send(8'h55, 0, "R3 data ignored 2", 1);
    chk("R3 divide unchanged", div_word, 15'h7FFF);
    stop_c();

    // select input moves the address
    addr_sel = 2'b10;
    start_c();
    addr(7'b1100010, 0, 1, "R2 select changed ack");
    send(8'h01, 1, "R2 byte2", 1);
    send(8'h02, 1, "R2 byte3", 1);
    chk("R2 divide via new address", div_word, 15'h0102);

    // repeated START mid pair
    send(8'h05, 1, "R10 staged byte2", 1);
    start_c();
    addr(7'b1100010, 0, 1, "R10 readdress ack");
    send(8'h81, 1, "R10 first after restart", 1);
    send(8'h40, 1, "R10 second after restart", 1);
    chk("R10 divide untouched", div_word, 15'h0102);
    chk("R10 ratio", ratio_sel, 5'h01);
    chk("R10 test mode", test_mode, 3'b010);
    stop_c();

    // read mode
    status_i = 8'hA5;
    start_c();
    addr(7'b1100010, 1, 1, "R2 read address ack");
    status_i = 8'h3C;
    rbyte(rd, 1);
    chk("R8 first status", rd, 8'hA5);
    status_i = 8'h96;
    rbyte(rd, 0);
    chk("R8 recaptured status", rd, 8'h3C);
    rbyte(rd, 0);
    chk("R9 released after master nack", rd, 8'hFF);
    stop_c();

    start_c();
    addr(7'b1100001, 1, 0, "R3 read mismatch no ack");
    rbyte(rd, 1);
    chk("R3 read mismatch silent", rd, 8'hFF);
    stop_c();
    q();

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule